// File: doc/BRIEF.md
# Reconfigurable Array Processing Element

This block is one cell of a reconfigurable datapath array. It pairs a two-operand functional unit with a transfer path. The transfer path forwards a third routed operand so that data can skip over a row. The functional unit combines operands A and B. Each operand is taken either from its routed input or from an immediate value held inside the cell. A separate configuration controller writes the control word and the immediate. The cell then processes one operand set per clock, with a single registered stage on both outputs.

A parameter fixes what kind of arithmetic unit the cell carries, because arrays of these cells alternate unit kinds by position. The default kind is an integer ALU. The other kind is a multiplier. A two-bit mode sets the role of the cell: functional unit only, transfer only, functional unit plus transfer, or two transfers. In the two-transfer role, the functional-unit output becomes a second forwarding lane for the routed A input.

Top module: `rpe_cell`

## Requirements
- R1: While `rst_n` is low, both outputs are zero. The configuration resets to mode 00 with opcode 000, both operand selects 0, and immediate 0. Before any load, the cell therefore adds the routed A and B.
- R2: A high `cfg_load` at a rising edge captures mode, opcode, both selects and the immediate. While `cfg_load` is low, the stored configuration does not change. A captured configuration governs the operands presented at every later edge.
- R3: Each operand select works on its own operand. Select 0 takes the routed input (`in_a` or `in_b`). Select 1 takes the stored immediate.
- R4: On the ALU kind (`MUL_KIND`=0), the opcodes are: 000 gives A+B modulo 2^W, 001 gives A-B modulo 2^W, 010 gives A AND B, 011 gives A OR B, 100 gives A XOR B.
- R5: Opcodes 101, 110 and 111 give zero on either kind.
- R6: On the multiplier kind (`MUL_KIND`=1), opcode 000 gives the low W bits of A×B. Every other opcode gives zero.
- R7: Both outputs have a latency of exactly one cycle. The operands and configuration present at an edge appear on the outputs just after that edge.
- R8: Mode 00 (functional unit only) drives the functional-unit result on `fu_out` and zero on `xfer_out`.
- R9: Mode 01 (transfer only) drives `in_c` on `xfer_out` and zero on `fu_out`.
- R10: Mode 10 (functional unit plus transfer) drives the functional-unit result on `fu_out` and `in_c` on `xfer_out`.
- R11: Mode 11 (two transfers) drives the routed `in_a` on `fu_out` and ignores the A select and the opcode. It drives `in_c` on `xfer_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration fields at this edge |
| cfg_mode | input | 2 | Role of the cell (00 FU, 01 transfer, 10 both, 11 dual transfer) |
| cfg_op | input | 3 | Functional-unit opcode |
| cfg_sel_a | input | 1 | Operand A source (1 = immediate) |
| cfg_sel_b | input | 1 | Operand B source (1 = immediate) |
| cfg_imm | input | W | Immediate value to store |
| in_a | input | W | Routed operand A |
| in_b | input | W | Routed operand B |
| in_c | input | W | Routed value for the transfer path |
| fu_out | output | W | Registered functional-unit lane |
| xfer_out | output | W | Registered transfer lane |

## Verification
The hardest case to reach from the ports is a configuration change mid-stream. The cycle with `cfg_load` high must still use the old control word, and the new word must govern only the next operand set. The stimulus therefore loads new words while operands keep changing, and it puts stale values on the configuration pins with `cfg_load` low. Dual-transfer mode is driven with the A select pointing at the immediate, to show that the immediate does not leak into that lane. A second instance of the multiplier kind runs on the same stimulus, so every opcode is seen by both unit kinds.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  localparam logic [1:0] MODE_FU      = 2'b00;
  localparam logic [1:0] MODE_XFER    = 2'b01;
  localparam logic [1:0] MODE_FU_XFER = 2'b10;
  localparam logic [1:0] MODE_DUAL    = 2'b11;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] op;
    logic       sel_a;
    logic       sel_b;
  } pe_ctl_t;
endpackage

// File: rtl/rpe_cfg_store.sv
module rpe_cfg_store
  import rpe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  pe_ctl_t       ctl_in,
  input  logic [W-1:0]  imm_in,
  output pe_ctl_t       ctl_q,
  output logic [W-1:0]  imm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      imm_q <= '0;
    end else if (load) begin
      ctl_q <= ctl_in;
      imm_q <= imm_in;
    end
  end
endmodule

// File: rtl/rpe_fu.sv
module rpe_fu
  import rpe_pkg::*;
#(
  parameter int W        = 8,
  parameter bit MUL_KIND = 1'b0
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] alu_eval(input logic [2:0] code,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] z);
    case (code)
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_AND:  return x & z;
      OP_OR:   return x | z;
      OP_XOR:  return x ^ z;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] mul_eval(input logic [2:0] code,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] z);
    logic [PW-1:0] prod;
    prod = PW'(x) * PW'(z);
    return (code == OP_ADD) ? prod[W-1:0] : '0;
  endfunction

  generate
    if (MUL_KIND) begin : g_mul
      assign y = mul_eval(op, a, b);
    end else begin : g_alu
      assign y = alu_eval(op, a, b);
    end
  endgenerate
endmodule

// File: rtl/rpe_cell.sv
module rpe_cell
  import rpe_pkg::*;
#(
  parameter int W        = 8,
  parameter bit MUL_KIND = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_load,
  input  logic [1:0]   cfg_mode,
  input  logic [2:0]   cfg_op,
  input  logic         cfg_sel_a,
  input  logic         cfg_sel_b,
  input  logic [W-1:0] cfg_imm,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] fu_out,
  output logic [W-1:0] xfer_out
);
  localparam int NOPND = 2;

  pe_ctl_t      ctl_in, ctl_q;
  logic [W-1:0] imm_q;
  logic [W-1:0] raw   [NOPND];
  logic [W-1:0] opnd  [NOPND];
  logic         sel   [NOPND];
  logic [W-1:0] fu_y, fu_d, xfer_d;
  logic         fu_active, xfer_active, dual_active;

  assign ctl_in = '{mode: cfg_mode, op: cfg_op, sel_a: cfg_sel_a, sel_b: cfg_sel_b};

  rpe_cfg_store #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .ctl_in(ctl_in), .imm_in(cfg_imm),
    .ctl_q(ctl_q), .imm_q(imm_q)
  );

  assign raw[0] = in_a;
  assign raw[1] = in_b;
  assign sel[0] = ctl_q.sel_a;
  assign sel[1] = ctl_q.sel_b;

  generate
    for (genvar i = 0; i < NOPND; i++) begin : g_opnd
      assign opnd[i] = sel[i] ? imm_q : raw[i];
    end
  endgenerate

  rpe_fu #(.W(W), .MUL_KIND(MUL_KIND)) u_fu (
    .op(ctl_q.op), .a(opnd[0]), .b(opnd[1]), .y(fu_y)
  );

  assign fu_active   = (ctl_q.mode == MODE_FU) || (ctl_q.mode == MODE_FU_XFER);
  assign dual_active = (ctl_q.mode == MODE_DUAL);
  assign xfer_active = (ctl_q.mode != MODE_FU);

  always_comb begin
    if (fu_active)        fu_d = fu_y;
    else if (dual_active) fu_d = in_a;
    else                  fu_d = '0;
  end

  assign xfer_d = xfer_active ? in_c : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fu_out   <= '0;
      xfer_out <= '0;
    end else begin
      fu_out   <= fu_d;
      xfer_out <= xfer_d;
    end
  end
endmodule

// File: rtl/rpe_cell_chk.sv
module rpe_cell_chk
  import rpe_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_load,
  input logic [1:0]   mode_q,
  input logic [2:0]   op_q,
  input logic         sel_a_q,
  input logic         sel_b_q,
  input logic [W-1:0] imm_q,
  input logic         fu_active,
  input logic         xfer_active,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_c,
  input logic [W-1:0] fu_out,
  input logic [W-1:0] xfer_out
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(!cfg_load) |-> (imm_q == $past(imm_q)) && (mode_q == $past(mode_q)) &&
                        (op_q == $past(op_q)) && (sel_a_q == $past(sel_a_q)) &&
                        (sel_b_q == $past(sel_b_q)));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(fu_active && (op_q >= 3'd5)) |-> (fu_out == '0));

  a_r7_xfer_latency: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(xfer_active) |-> (xfer_out == $past(in_c)));

  a_r8_xfer_idle: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(mode_q == MODE_FU) |-> (xfer_out == '0));

  a_r9_fu_idle: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(mode_q == MODE_XFER) |-> (fu_out == '0));

  a_r11_dual_raw: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(mode_q == MODE_DUAL) |-> (fu_out == $past(in_a)));
endmodule

bind rpe_cell rpe_cell_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
  .mode_q(ctl_q.mode), .op_q(ctl_q.op), .sel_a_q(ctl_q.sel_a), .sel_b_q(ctl_q.sel_b),
  .imm_q(imm_q), .fu_active(fu_active), .xfer_active(xfer_active),
  .in_a(in_a), .in_c(in_c), .fu_out(fu_out), .xfer_out(xfer_out)
);

// File: tb/rpe_cell_bench.sv
module rpe_cell_bench;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [1:0]   cfg_mode = '0;
  logic [2:0]   cfg_op = '0;
  logic         cfg_sel_a = 1'b0, cfg_sel_b = 1'b0;
  logic [W-1:0] cfg_imm = '0, in_a = '0, in_b = '0, in_c = '0;
  logic [W-1:0] fu_alu, x_alu, fu_mul, x_mul;

  int vectors = 0, bad = 0;
  bit done = 0;
  int m_mode = 0, m_op = 0, m_sa = 0, m_sb = 0, m_imm = 0;

  always #10 clk = ~clk;

  rpe_cell #(.W(W), .MUL_KIND(1'b0)) u_rpe_cell (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_op(cfg_op),
    .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b), .cfg_imm(cfg_imm),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .fu_out(fu_alu), .xfer_out(x_alu));

  rpe_cell #(.W(W), .MUL_KIND(1'b1)) u_rpe_cell_mul (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_op(cfg_op),
    .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b), .cfg_imm(cfg_imm),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .fu_out(fu_mul), .xfer_out(x_mul));

  function automatic int ref_unit(int op, int a, int b, bit mul);
    if (op >= 5) return 0;
    if (mul) return (op == 0) ? ((a * b) & MASK) : 0;
    if (op == 0) return (a + b) & MASK;
    if (op == 1) return (a - b) & MASK;
    if (op == 2) return a & b;
    if (op == 3) return a | b;
    return a ^ b;
  endfunction

  function automatic int ref_fu(int a, int b, bit mul);
    int oa = m_sa ? m_imm : a;
    int ob = m_sb ? m_imm : b;
    if (m_mode == 3) return a;
    if (m_mode == 1) return 0;
    return ref_unit(m_op, oa, ob, mul);
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag);
    int e_alu = ref_fu(int'(in_a), int'(in_b), 1'b0);
    int e_mul = ref_fu(int'(in_a), int'(in_b), 1'b1);
    int e_x   = (m_mode == 0) ? 0 : int'(in_c);
    if (cfg_load) begin
      m_mode = cfg_mode; m_op = cfg_op; m_sa = cfg_sel_a; m_sb = cfg_sel_b; m_imm = cfg_imm;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "alu fu_out", fu_alu, e_alu);
    check(tag, "mul fu_out", fu_mul, e_mul);
    check(tag, "alu xfer_out", x_alu, e_x);
    check(tag, "mul xfer_out", x_mul, e_x);
  endtask

  task automatic set_cfg(bit ld, int mode, int op, bit sa, bit sb, int imm);
    cfg_load = ld; cfg_mode = 2'(mode); cfg_op = 3'(op);
    cfg_sel_a = sa; cfg_sel_b = sb; cfg_imm = W'(imm);
  endtask

  task automatic set_in(int a, int b, int c);
    in_a = W'(a); in_b = W'(b); in_c = W'(c);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    set_in(8'h5a, 8'h33, 8'h77);
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1", "alu fu_out in reset", fu_alu, 0);
    check("R1", "alu xfer_out in reset", x_alu, 0);
    check("R1", "mul fu_out in reset", fu_mul, 0);
    rst_n = 1'b1;
    // R1: reset configuration adds routed operands, no transfer
    set_in(200, 100, 9); step("R1");
    set_in(3, 4, 5);     step("R7");

    // R4 R5 R6 R10: every opcode in mode 10 on routed operands
    for (int op = 0; op < 8; op++) begin
      set_cfg(1, 2, op, 0, 0, 0); set_in(17, 250, op); step("R2");
      set_cfg(0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 4; k++) begin
        set_in($urandom_range(0, MASK), $urandom_range(0, MASK), $urandom_range(0, MASK));
        step(op >= 5 ? "R5" : (op == 0 ? "R6" : "R4"));
      end
      set_in(0, 255, 1); step("R10");
      set_in(255, 255, 2); step("R4");
    end

    // R3: immediate substitution per operand
    for (int s = 0; s < 4; s++) begin
      set_cfg(1, 0, 1, s[0], s[1], 8'hc3); set_in(10, 20, 30); step("R3");
      set_cfg(0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 3; k++) begin
        set_in($urandom_range(0, MASK), $urandom_range(0, MASK), $urandom_range(0, MASK));
        step("R3");
      end
    end

    // R2: configuration pins wiggle without load; stored word must hold
    set_cfg(1, 0, 4, 1, 0, 8'h0f); set_in(1, 2, 3); step("R2");
    for (int k = 0; k < 6; k++) begin
      set_cfg(0, k % 4, k, k[0], ~k[0], 8'hff - k);
      set_in($urandom_range(0, MASK), $urandom_range(0, MASK), $urandom_range(0, MASK));
      step("R2");
    end

    // R8 R9 R11: each role; dual with immediate select on A must be ignored
    set_cfg(1, 0, 0, 0, 0, 0); set_in(5, 6, 7); step("R8");
    set_cfg(0, 0, 0, 0, 0, 0); set_in(9, 9, 200); step("R8");
    set_cfg(1, 1, 0, 0, 0, 0); set_in(5, 6, 7); step("R9");
    set_cfg(0, 0, 0, 0, 0, 0); set_in(44, 55, 66); step("R9");
    set_cfg(1, 3, 1, 1, 1, 8'haa); set_in(5, 6, 7); step("R11");
    set_cfg(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      set_in($urandom_range(0, MASK), $urandom_range(0, MASK), $urandom_range(0, MASK));
      step("R11");
    end

    // R7: long random run with loads mixed in
    for (int k = 0; k < 400; k++) begin
      set_cfg(($urandom_range(0, 3) == 0), $urandom_range(0, 3), $urandom_range(0, 7),
              $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, MASK));
      set_in($urandom_range(0, MASK), $urandom_range(0, MASK), $urandom_range(0, MASK));
      step("R7");
    end

    done = 1;
    finish_run();
  end
endmodule